// File: doc/BRIEF.md
# Control Structure State Tracker

This block keeps the bookkeeping a virtualization unit needs for its per-guest control structures. It does not read or write the structures in memory. It holds a small table of slots. Each slot records whether a structure is active, whether that structure has been launched, and the page address where the structure lives. One current-pointer register selects at most one active slot. Commands arrive one per cycle, and each command is answered exactly one cycle later with a pass or fail flag and an error code.

A load command carries the target page address and the 32-bit header word already fetched from that page. The block checks the alignment, the revision number and the shadow marker. It then either allocates a slot or reselects an existing one, and makes that slot current. A clear command retires a structure and resets its launch state. The launch command requires that the current structure has not been launched yet. The resume command requires that it has. A store command returns the current pointer. The current pointer is also visible on a port at all times, and it reads as all ones when nothing is current.

Top module: `cs_tracker`

## Requirements
- R1: After reset the table is empty and no structure is current. At most one structure is current at any time. `cur_ptr` shows the current page address with bits 11:0 zero, or all ones when none is current.
- R2: A load that passes its checks makes the addressed structure active and current. A newly allocated structure starts in the not-launched state. A structure that was already active keeps its launch state.
- R3: A clear of an aligned address succeeds. It makes that structure inactive and resets its launch state. If the structure was current, `cur_ptr` becomes all ones. Clearing an address that is not in the table changes nothing.
- R4: A launch succeeds only when the current structure is not launched, and success marks it launched. Otherwise it fails with code 6.
- R5: A resume succeeds only when the current structure is launched, and it changes no state. Otherwise it fails with code 6.
- R6: A load or clear whose address has any nonzero bit in 11:0 fails with code 1 and leaves the table and the current pointer unchanged.
- R7: A load whose header bits 30:0 differ from `exp_rev` fails with code 2.
- R8: A load whose header bit 31 is set while `shadow_ok` is 0 fails with code 3. When `shadow_ok` is 1, the same load is accepted.
- R9: A launch or resume with no current structure fails with code 5.
- R10: A load of an address that is not in the table fails with code 4 when every slot is active. A load of an address that is already active still succeeds.
- R11: A store always succeeds. Its `rsp_ptr` is the current pointer, or all ones when none is current.
- R12: `rsp_valid` is high exactly in the cycle after `cmd_valid`. A success has code 0 and a failure a nonzero code. Load checks rank alignment (1), then revision (2), then shadow (3), then capacity (4). Opcodes are 1 load, 2 clear, 3 launch, 4 resume, 5 store. Any other opcode fails with code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | ADDR_W (64) | Structure page address for load and clear |
| cmd_hdr | input | HDR_W (32) | Header word of the addressed region, used by load |
| exp_rev | input | HDR_W-1 (31) | Revision number the block accepts |
| shadow_ok | input | 1 | High when shadow structures are supported |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Command succeeded |
| rsp_err | output | 3 | Error code, 0 on success |
| rsp_ptr | output | ADDR_W (64) | Current pointer returned by a store, zero otherwise |
| cur_ptr | output | ADDR_W (64) | Current structure address, all ones if none |

## Verification
Several properties are checked on every cycle against the ports. These are the form of the current pointer, the one-cycle response timing, the consistency between the pass flag and the error code, and the failure codes for misaligned, wrong-revision, unsupported-shadow and no-current commands. The assertions also check that a successful load exposes the loaded address and that clearing the current structure empties the pointer. Other behaviour depends on history the assertions do not track. This covers the launch-state rules across reloads and clears, capacity exhaustion, and reuse of a freed slot, and only the directed scenarios in the bench can show it.

// File: rtl/cst_pkg.sv
// Shared opcodes, error codes and helpers for the control structure tracker.
// Assumes opcode and error encodings are fixed at 3 bits.
package cst_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_CLEAR  = 3'd2,
        OP_LAUNCH = 3'd3,
        OP_RESUME = 3'd4,
        OP_STORE  = 3'd5
    } cst_op_e;

    typedef enum logic [2:0] {
        E_NONE   = 3'd0,
        E_ALIGN  = 3'd1,
        E_REV    = 3'd2,
        E_SHADOW = 3'd3,
        E_FULL   = 3'd4,
        E_NOCUR  = 3'd5,
        E_STATE  = 3'd6,
        E_BADOP  = 3'd7
    } cst_err_e;

endpackage

// File: rtl/cst_match.sv
// Associative lookup over the slot table: finds the active slot whose page
// tag equals the command tag, and the lowest-numbered free slot.
// Assumes at most one active slot holds a given tag (the loader keeps it so).
module cst_match #(
    parameter int SLOTS = 4,
    parameter int TAG_W = 52,
    parameter int IDX_W = 2
) (
    input  logic [SLOTS-1:0]            valid,
    input  logic [SLOTS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx,
    output logic                        has_free,
    output logic [IDX_W-1:0]            free_idx
);

    logic [SLOTS-1:0] hit_vec;

    // One comparator per slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        assign hit_vec[s] = valid[s] && (tags[s] == key);
    end

    // Encode the hit vector and pick the lowest free slot.
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx  = IDX_W'(i);
            if (!valid[i])  free_idx = IDX_W'(i);
        end
    end

    assign hit      = |hit_vec;
    assign has_free = ~&valid;

endmodule

// File: rtl/cst_table.sv
// Slot storage: per slot an active flag, a launched flag and the page tag.
// Assumes the controller never requests two updates to the same slot in one cycle.
module cst_table #(
    parameter int SLOTS = 4,
    parameter int TAG_W = 52,
    parameter int IDX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc,
    input  logic [IDX_W-1:0]            alloc_idx,
    input  logic [TAG_W-1:0]            alloc_tag,
    input  logic                        inval,
    input  logic [IDX_W-1:0]            inval_idx,
    input  logic                        mark,
    input  logic [IDX_W-1:0]            mark_idx,
    output logic [SLOTS-1:0]            valid,
    output logic [SLOTS-1:0][TAG_W-1:0] tags,
    output logic [SLOTS-1:0]            launched
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic             v_q;
        logic             l_q;
        logic [TAG_W-1:0] t_q;

        // Update one slot on allocate, invalidate or launch-mark.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                l_q <= 1'b0;
                t_q <= '0;
            end else if (alloc && alloc_idx == IDX_W'(s)) begin
                v_q <= 1'b1;
                l_q <= 1'b0;
                t_q <= alloc_tag;
            end else if (inval && inval_idx == IDX_W'(s)) begin
                v_q <= 1'b0;
                l_q <= 1'b0;
            end else if (mark && mark_idx == IDX_W'(s)) begin
                l_q <= 1'b1;
            end
        end

        assign valid[s]    = v_q;
        assign launched[s] = l_q;
        assign tags[s]     = t_q;
    end

endmodule

// File: rtl/cst_decide.sv
// Combinational command decoder: applies the checks for each opcode and
// produces the pass/fail result plus the table and current-pointer updates.
// Assumes inputs describe the state before the command takes effect.
module cst_decide
    import cst_pkg::*;
#(
    parameter int HDR_W = 32,
    parameter int IDX_W = 2
) (
    input  logic             cmd_valid,
    input  cst_op_e          op,
    input  logic             aligned,
    input  logic [HDR_W-1:0] hdr,
    input  logic [HDR_W-2:0] exp_rev,
    input  logic             shadow_ok,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             has_free,
    input  logic [IDX_W-1:0] free_idx,
    input  logic             cur_vld,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             cur_launched,
    output logic             ok,
    output cst_err_e         err,
    output logic             alloc,
    output logic             inval,
    output logic             mark,
    output logic             set_cur,
    output logic [IDX_W-1:0] new_cur_idx,
    output logic             drop_cur
);

    // Decide the outcome and side effects of the presented command.
    always_comb begin
        ok          = 1'b0;
        err         = E_NONE;
        alloc       = 1'b0;
        inval       = 1'b0;
        mark        = 1'b0;
        set_cur     = 1'b0;
        drop_cur    = 1'b0;
        new_cur_idx = hit_idx;
        if (cmd_valid) begin
            case (op)
                OP_LOAD: begin
                    if (!aligned)                           err = E_ALIGN;
                    else if (hdr[HDR_W-2:0] != exp_rev)     err = E_REV;
                    else if (hdr[HDR_W-1] && !shadow_ok)    err = E_SHADOW;
                    else if (hit) begin
                        ok      = 1'b1;
                        set_cur = 1'b1;
                    end else if (has_free) begin
                        ok          = 1'b1;
                        alloc       = 1'b1;
                        set_cur     = 1'b1;
                        new_cur_idx = free_idx;
                    end else                                err = E_FULL;
                end
                OP_CLEAR: begin
                    if (!aligned) err = E_ALIGN;
                    else begin
                        ok = 1'b1;
                        if (hit) begin
                            inval    = 1'b1;
                            drop_cur = cur_vld && (cur_idx == hit_idx);
                        end
                    end
                end
                OP_LAUNCH: begin
                    if (!cur_vld)          err = E_NOCUR;
                    else if (cur_launched) err = E_STATE;
                    else begin
                        ok   = 1'b1;
                        mark = 1'b1;
                    end
                end
                OP_RESUME: begin
                    if (!cur_vld)           err = E_NOCUR;
                    else if (!cur_launched) err = E_STATE;
                    else                    ok  = 1'b1;
                end
                OP_STORE: ok  = 1'b1;
                default:  err = E_BADOP;
            endcase
        end
    end

endmodule

// File: rtl/cs_tracker.sv
// Control structure state tracker top: slot table, lookup, command decoder,
// current-pointer register and registered one-cycle response.
// Assumes SLOTS >= 2 and PAGE_W < ADDR_W; one command per cycle at most.
module cs_tracker
    import cst_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 64,
    parameter int PAGE_W = 12,
    parameter int HDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [HDR_W-1:0]  cmd_hdr,
    input  logic [HDR_W-2:0]  exp_rev,
    input  logic              shadow_ok,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [2:0]        rsp_err,
    output logic [ADDR_W-1:0] rsp_ptr,
    output logic [ADDR_W-1:0] cur_ptr
);

    localparam int TAG_W = ADDR_W - PAGE_W;
    localparam int IDX_W = $clog2(SLOTS);

    logic [SLOTS-1:0]            valid;
    logic [SLOTS-1:0][TAG_W-1:0] tags;
    logic [SLOTS-1:0]            launched;
    logic                        hit, has_free;
    logic [IDX_W-1:0]            hit_idx, free_idx;
    logic                        cur_vld;
    logic [IDX_W-1:0]            cur_idx;
    logic                        ok, alloc, inval, mark, set_cur, drop_cur;
    logic [IDX_W-1:0]            new_cur_idx;
    cst_err_e                    err;
    logic                        aligned;
    cst_op_e                     op;

    assign aligned = (cmd_addr[PAGE_W-1:0] == '0);
    assign op      = cst_op_e'(cmd_op);

    cst_match #(.SLOTS(SLOTS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .valid    (valid),
        .tags     (tags),
        .key      (cmd_addr[ADDR_W-1:PAGE_W]),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .has_free (has_free),
        .free_idx (free_idx)
    );

    cst_decide #(.HDR_W(HDR_W), .IDX_W(IDX_W)) u_decide (
        .cmd_valid    (cmd_valid),
        .op           (op),
        .aligned      (aligned),
        .hdr          (cmd_hdr),
        .exp_rev      (exp_rev),
        .shadow_ok    (shadow_ok),
        .hit          (hit),
        .hit_idx      (hit_idx),
        .has_free     (has_free),
        .free_idx     (free_idx),
        .cur_vld      (cur_vld),
        .cur_idx      (cur_idx),
        .cur_launched (launched[cur_idx]),
        .ok           (ok),
        .err          (err),
        .alloc        (alloc),
        .inval        (inval),
        .mark         (mark),
        .set_cur      (set_cur),
        .new_cur_idx  (new_cur_idx),
        .drop_cur     (drop_cur)
    );

    cst_table #(.SLOTS(SLOTS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (alloc),
        .alloc_idx (free_idx),
        .alloc_tag (cmd_addr[ADDR_W-1:PAGE_W]),
        .inval     (inval),
        .inval_idx (hit_idx),
        .mark      (mark),
        .mark_idx  (cur_idx),
        .valid     (valid),
        .tags      (tags),
        .launched  (launched)
    );

    // Current-pointer register: set by a passing load, dropped by clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vld <= 1'b0;
            cur_idx <= '0;
        end else if (set_cur) begin
            cur_vld <= 1'b1;
            cur_idx <= new_cur_idx;
        end else if (drop_cur) begin
            cur_vld <= 1'b0;
        end
    end

    assign cur_ptr = cur_vld ? {tags[cur_idx], {PAGE_W{1'b0}}} : {ADDR_W{1'b1}};

    // Response register: result of the command from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= 3'd0;
            rsp_ptr   <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_ok    <= ok;
            rsp_err   <= err;
            rsp_ptr   <= (cmd_valid && op == OP_STORE) ? cur_ptr : '0;
        end
    end

endmodule

// File: rtl/cst_checker.sv
// Port-level properties for cs_tracker, attached with bind.
// Assumes the opcode and error encodings of cst_pkg.
module cst_checker
    import cst_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PAGE_W = 12,
    parameter int HDR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [HDR_W-1:0]  cmd_hdr,
    input logic [HDR_W-2:0]  exp_rev,
    input logic              shadow_ok,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic [2:0]        rsp_err,
    input logic [ADDR_W-1:0] cur_ptr
);

    logic ld, cl, lr;
    assign ld = cmd_valid && cmd_op == OP_LOAD;
    assign cl = cmd_valid && cmd_op == OP_CLEAR;
    assign lr = cmd_valid && (cmd_op == OP_LAUNCH || cmd_op == OP_RESUME);

    a_r1_ptr_form: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ptr[PAGE_W-1:0] == '0) || (cur_ptr == {ADDR_W{1'b1}}));

    a_r2_load_current: assert property (@(posedge clk) disable iff (!rst_n)
        ld && !$isunknown(cmd_addr) |=> !rsp_ok || (cur_ptr == $past(cmd_addr)));

    a_r3_clear_current: assert property (@(posedge clk) disable iff (!rst_n)
        cl && cmd_addr == cur_ptr |=> rsp_ok && cur_ptr == {ADDR_W{1'b1}});

    a_r5_resume_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_RESUME |=> $stable(cur_ptr));

    a_r6_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (ld || cl) && cmd_addr[PAGE_W-1:0] != '0 |=> !rsp_ok && rsp_err == E_ALIGN && $stable(cur_ptr));

    a_r7_revision: assert property (@(posedge clk) disable iff (!rst_n)
        ld && cmd_addr[PAGE_W-1:0] == '0 && cmd_hdr[HDR_W-2:0] != exp_rev |=> !rsp_ok && rsp_err == E_REV);

    a_r8_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        ld && cmd_addr[PAGE_W-1:0] == '0 && cmd_hdr[HDR_W-2:0] == exp_rev && cmd_hdr[HDR_W-1] && !shadow_ok
        |=> !rsp_ok && rsp_err == E_SHADOW);

    a_r9_no_current: assert property (@(posedge clk) disable iff (!rst_n)
        lr && cur_ptr == {ADDR_W{1'b1}} |=> !rsp_ok && rsp_err == E_NOCUR);

    a_r12_timing: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    a_r12_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok == (rsp_err == E_NONE)));

endmodule

bind cs_tracker cst_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .HDR_W  (HDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_hdr   (cmd_hdr),
    .exp_rev   (exp_rev),
    .shadow_ok (shadow_ok),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_err   (rsp_err),
    .cur_ptr   (cur_ptr)
);

// File: tb/sim_cs_tracker.sv
// Directed bench for cs_tracker: one task per scenario, each self-checking.
module sim_cs_tracker;

    localparam logic [30:0] REV  = 31'h0000_0ABC;
    localparam logic [31:0] HOK  = {1'b0, REV};
    localparam logic [63:0] NONE = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] PA   = 64'h0000_0000_0000_1000;
    localparam logic [63:0] PB   = 64'h0000_0000_0002_3000;
    localparam logic [63:0] PC   = 64'h0000_00F0_0000_0000;
    localparam logic [63:0] PD   = 64'h8000_0000_0000_5000;
    localparam logic [63:0] PE   = 64'h0000_0000_0000_7000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [63:0] cmd_addr = '0;
    logic [31:0] cmd_hdr = '0;
    logic [30:0] exp_rev = REV;
    logic        shadow_ok = 1'b0;
    logic        rsp_valid, rsp_ok;
    logic [2:0]  rsp_err;
    logic [63:0] rsp_ptr, cur_ptr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cs_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_hdr(cmd_hdr), .exp_rev(exp_rev),
        .shadow_ok(shadow_ok), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_err(rsp_err), .rsp_ptr(rsp_ptr), .cur_ptr(cur_ptr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one command for one cycle; return just after the response edge.
    task automatic issue(input logic [2:0] op, input logic [63:0] addr, input logic [31:0] hdr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_hdr = hdr;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    // Response check: valid, pass flag and code packed together.
    task automatic rsp(input string req, input logic ok, input logic [2:0] err);
        chk(req, {59'd0, rsp_valid, rsp_ok, rsp_err}, {59'd0, 1'b1, ok, err});
    endtask

    task automatic t_reset;
        chk("R1 reset cur_ptr", cur_ptr, NONE);
        chk("R12 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
        issue(3'd3, '0, '0);
        rsp("R9 launch without current", 1'b0, 3'd5);
        issue(3'd5, '0, '0);
        rsp("R11 store empty", 1'b1, 3'd0);
        chk("R11 store empty ptr", rsp_ptr, NONE);
    endtask

    task automatic t_lifecycle;
        issue(3'd1, PA, HOK);
        rsp("R2 load", 1'b1, 3'd0);
        chk("R2 current after load", cur_ptr, PA);
        issue(3'd4, '0, '0);
        rsp("R5 resume before launch", 1'b0, 3'd6);
        issue(3'd3, '0, '0);
        rsp("R4 first launch", 1'b1, 3'd0);
        issue(3'd3, '0, '0);
        rsp("R4 second launch", 1'b0, 3'd6);
        issue(3'd4, '0, '0);
        rsp("R5 resume launched", 1'b1, 3'd0);
        chk("R5 pointer kept", cur_ptr, PA);
        issue(3'd5, '0, '0);
        chk("R11 store ptr", rsp_ptr, PA);
    endtask

    task automatic t_checks;
        issue(3'd1, PB | 64'h4, HOK);
        rsp("R6 misaligned load", 1'b0, 3'd1);
        chk("R6 pointer unchanged", cur_ptr, PA);
        issue(3'd2, PA | 64'h800, HOK);
        rsp("R6 misaligned clear", 1'b0, 3'd1);
        issue(3'd4, '0, '0);
        rsp("R6 entry still launched", 1'b1, 3'd0);
        issue(3'd1, PB, {1'b0, REV ^ 31'h1});
        rsp("R7 revision mismatch", 1'b0, 3'd2);
        chk("R7 pointer unchanged", cur_ptr, PA);
        issue(3'd1, PB | 64'h1, {1'b1, ~REV});
        rsp("R12 alignment ranks first", 1'b0, 3'd1);
        issue(3'd1, PB, {1'b1, ~REV});
        rsp("R12 revision ranks before shadow", 1'b0, 3'd2);
        issue(3'd1, PB, {1'b1, REV});
        rsp("R8 shadow unsupported", 1'b0, 3'd3);
        shadow_ok = 1'b1;
        issue(3'd1, PB, {1'b1, REV});
        rsp("R8 shadow supported", 1'b1, 3'd0);
        chk("R8 pointer moved", cur_ptr, PB);
        shadow_ok = 1'b0;
        issue(3'd4, '0, '0);
        rsp("R2 new entry not launched", 1'b0, 3'd6);
        issue(3'd1, PA, HOK);
        issue(3'd4, '0, '0);
        rsp("R2 reload keeps launched", 1'b1, 3'd0);
    endtask

    task automatic t_clear;
        issue(3'd2, PA, '0);
        rsp("R3 clear current", 1'b1, 3'd0);
        chk("R3 pointer empty", cur_ptr, NONE);
        issue(3'd4, '0, '0);
        rsp("R9 resume without current", 1'b0, 3'd5);
        issue(3'd1, PA, HOK);
        issue(3'd4, '0, '0);
        rsp("R3 launch state reset", 1'b1 ^ 1'b1, 3'd6);
        issue(3'd2, 64'h9000, '0);
        rsp("R3 clear absent", 1'b1, 3'd0);
        chk("R3 absent leaves pointer", cur_ptr, PA);
    endtask

    task automatic t_full;
        issue(3'd1, PC, HOK);
        rsp("R10 third slot", 1'b1, 3'd0);
        issue(3'd1, PD, HOK);
        rsp("R10 fourth slot", 1'b1, 3'd0);
        issue(3'd1, PE, HOK);
        rsp("R10 table full", 1'b0, 3'd4);
        chk("R10 pointer kept", cur_ptr, PD);
        issue(3'd1, PB, HOK);
        rsp("R10 existing loads when full", 1'b1, 3'd0);
        chk("R10 pointer to existing", cur_ptr, PB);
        issue(3'd2, PC, '0);
        issue(3'd1, PE, HOK);
        rsp("R10 freed slot reused", 1'b1, 3'd0);
        chk("R10 pointer new", cur_ptr, PE);
    endtask

    task automatic t_badop;
        issue(3'd0, '0, '0);
        rsp("R12 opcode 0", 1'b0, 3'd7);
        issue(3'd7, '0, '0);
        rsp("R12 opcode 7", 1'b0, 3'd7);
        chk("R12 bad op keeps pointer", cur_ptr, PE);
        @(posedge clk); #1;
        chk("R12 no response when idle", {63'd0, rsp_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_lifecycle();
        t_checks();
        t_clear();
        t_full();
        t_badop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule